// File: doc/BRIEF.md
# Masked Content-Addressable Search Memory

This block holds a small table of words, each tagged with a valid flag, and answers the question "which stored words agree with this pattern on these bit positions?". A requester presents a pattern (`arg`) and a bit-enable (`mask`) and pulses `search_start`. Every stored word is compared at the same time, and the set of agreeing locations is captured in a hit vector. That search also freezes a private copy of the table's contents.

The requester then pulses `read_next` once per word wanted. Each pulse returns the lowest-index location still marked in the hit vector and removes it from the set. `done` rises once the set is empty. Entries are loaded through a simple write port that carries an index, a data word and a valid flag. Loads that land while a readout is in progress do not disturb the words being returned. They take effect at the next search.

A typical use is a tag lookup. The upper bits of each word hold a tag, and the mask enables only those bits. For example, `mask = 16'hF000` with `arg = 16'hF000` selects every valid word whose top four bits are all ones.

Top module: `argmask_cam`

## Requirements
- R1: When `wr_en` is 1 at a rising edge, location `wr_idx` takes `wr_data` and its valid flag takes `wr_valid`. A search started in any later cycle uses the new contents.
- R2: A search samples `arg`, `mask` and the table at the rising edge where `search_start` is 1. Location i is marked when it is valid and `((word_i ^ arg) & mask) == 0`. Bit positions where `mask` is 0 are ignored.
- R3: A location whose valid flag is 0 is never marked, whatever its data.
- R4: After a search, each `read_next` pulse while marks remain does two things. `rd_valid` is 1 in the following cycle only, with `rd_data` equal to the word at the lowest marked index, and that mark is removed. Successive reads therefore return words in ascending index order.
- R5: A `read_next` pulse when no marks remain, or before any search, leaves `rd_valid` at 0 in the following cycle.
- R6: `done` is 0 from reset until the first search. From the cycle after a search, `done` is 1 exactly when no marks remain. A search with no matches gives `done` = 1 in the cycle after it.
- R7: The words returned by a readout are the table contents at the search edge. A write during the readout, or in the same cycle as `search_start`, changes neither the marks nor the returned data of that search. It is seen by the next search.
- R8: An all-zero `mask` marks every valid location.
- R9: When `search_start` and `read_next` are both 1 in one cycle, the search is performed and the read is ignored (`rd_valid` stays 0 in the next cycle). A new search discards any marks left from the previous one.
- R10: While `rst_n` is 0 at a rising edge, all locations become invalid, and `rd_valid` and `done` are 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for one table location |
| wr_idx | input | 3 | Location to write |
| wr_data | input | 16 | Word to store |
| wr_valid | input | 1 | Valid flag to store with the word |
| arg | input | 16 | Search pattern |
| mask | input | 16 | Bit enable for the comparison (1 = compare) |
| search_start | input | 1 | Start a search |
| read_next | input | 1 | Request the next marked word |
| rd_data | output | 16 | Word returned by the last successful read |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` is new |
| done | output | 1 | No marked words remain in the current search |

## Verification
The bench targets the cases a faulty design would get wrong:
- **Ordering.** Several entries match, including non-adjacent ones, and the readout order is checked. A picker that favours the highest index, or that skips a bit, returns the words in the wrong order.
- **Stale data.** A location is rewritten in the middle of a readout, and in the same cycle as a search. A design that reads the live table returns the new data in the first case, and one that forwards the write into the compare marks the new word in the second.
- **Invalid entries and empty mask.** Invalid entries carry data that would otherwise match, and the all-zero mask is exercised. A design that drops the valid term returns those entries.
- **Colliding strobes and surplus reads.** The search-plus-read collision and reads past the end are covered. Mishandling either shows up as an unexpected `rd_valid` pulse or as a `done` that never rises.

// File: rtl/cam_pkg.sv
// cam_pkg: default geometry shared by the search memory and its bench.
// Assumes nothing beyond the two sizes below; derived widths are computed
// where they are used.
package cam_pkg;
    localparam int CAM_WORDS = 8;
    localparam int CAM_WIDTH = 16;
endpackage

// File: rtl/cam_store.sv
// cam_store: register table of WORDS entries, each WIDTH data bits plus a
// valid flag. One write per cycle. Reset clears every valid flag and word.
// Assumes wr_idx < WORDS when wr_en is high.
module cam_store #(
    parameter int WORDS = 8,
    parameter int WIDTH = 16,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [WIDTH-1:0]             wr_data,
    input  logic                         wr_valid,
    output logic [WORDS-1:0][WIDTH-1:0]  words,
    output logic [WORDS-1:0]             valid
);
    // Table update: reset clears all entries, otherwise write one location.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            words <= '0;
            valid <= '0;
        end else if (wr_en) begin
            words[wr_idx] <= wr_data;
            valid[wr_idx] <= wr_valid;
        end
    end
endmodule

// File: rtl/cam_compare.sv
// cam_compare: one masked equality comparator per table entry, all working
// in parallel. An entry hits when it is valid and agrees with arg on every
// bit enabled in mask. Purely combinational.
module cam_compare #(
    parameter int WORDS = 8,
    parameter int WIDTH = 16
) (
    input  logic [WORDS-1:0][WIDTH-1:0]  words,
    input  logic [WORDS-1:0]             valid,
    input  logic [WIDTH-1:0]             arg,
    input  logic [WIDTH-1:0]             mask,
    output logic [WORDS-1:0]             hit
);
    for (genvar g = 0; g < WORDS; g++) begin : g_cmp
        // Per-entry compare: only masked-in differing bits defeat a hit.
        assign hit[g] = valid[g] && (((words[g] ^ arg) & mask) == '0);
    end
endmodule

// File: rtl/cam_pick.sv
// cam_pick: finds the lowest set bit of vec and returns it both as a
// one-hot vector and as a binary index; any is high when vec is non-zero.
// Combinational; outputs are zero when vec is zero.
module cam_pick #(
    parameter int WORDS = 8,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic [WORDS-1:0]  vec,
    output logic [WORDS-1:0]  onehot,
    output logic [IDX_W-1:0]  idx,
    output logic              any
);
    // Scan from the top down so the lowest set bit is the last one kept.
    always_comb begin
        onehot = '0;
        idx    = '0;
        for (int i = WORDS - 1; i >= 0; i--) begin
            if (vec[i]) begin
                onehot    = '0;
                onehot[i] = 1'b1;
                idx       = IDX_W'(i);
            end
        end
    end

    assign any = |vec;
endmodule

// File: rtl/argmask_cam.sv
// argmask_cam: masked associative search memory. A search marks every
// valid entry that agrees with arg on the bits enabled by mask, and freezes
// a copy of the table. Each read_next then returns the lowest marked word
// of that copy and clears its mark; done shows that no marks remain.
// Assumes a single requester; search_start takes priority over read_next.
module argmask_cam #(
    parameter int WORDS = cam_pkg::CAM_WORDS,
    parameter int WIDTH = cam_pkg::CAM_WIDTH,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic              wr_valid,
    input  logic [WIDTH-1:0]  arg,
    input  logic [WIDTH-1:0]  mask,
    input  logic              search_start,
    input  logic              read_next,
    output logic [WIDTH-1:0]  rd_data,
    output logic              rd_valid,
    output logic              done
);
    logic [WORDS-1:0][WIDTH-1:0] tbl_words;
    logic [WORDS-1:0]            ent_valid;
    logic [WORDS-1:0]            hit_now;
    logic [WORDS-1:0]            match_q;
    logic [WORDS-1:0][WIDTH-1:0] snap_q;
    logic                        searched_q;
    logic [WORDS-1:0]            pick_oh;
    logic [IDX_W-1:0]            pick_idx;
    logic                        pick_any;

    cam_store #(.WORDS(WORDS), .WIDTH(WIDTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .wr_valid (wr_valid),
        .words    (tbl_words),
        .valid    (ent_valid)
    );

    cam_compare #(.WORDS(WORDS), .WIDTH(WIDTH)) u_cmp (
        .words (tbl_words),
        .valid (ent_valid),
        .arg   (arg),
        .mask  (mask),
        .hit   (hit_now)
    );

    cam_pick #(.WORDS(WORDS)) u_pick (
        .vec    (match_q),
        .onehot (pick_oh),
        .idx    (pick_idx),
        .any    (pick_any)
    );

    // Search capture and sequential readout of the marked words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q    <= '0;
            snap_q     <= '0;
            searched_q <= 1'b0;
            rd_data    <= '0;
            rd_valid   <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            if (search_start) begin
                match_q    <= hit_now;
                snap_q     <= tbl_words;
                searched_q <= 1'b1;
            end else if (read_next && pick_any) begin
                rd_data  <= snap_q[pick_idx];
                rd_valid <= 1'b1;
                match_q  <= match_q & ~pick_oh;
            end
        end
    end

    // Completion flag: a search has run and nothing is left to read.
    assign done = searched_q && (match_q == '0);
endmodule

// File: rtl/argmask_cam_checker.sv
// argmask_cam_checker: protocol and state properties of argmask_cam,
// attached through bind. Observes ports and the internal mark vector.
module argmask_cam_checker #(
    parameter int WORDS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             search_start,
    input logic             read_next,
    input logic             rd_valid,
    input logic             done,
    input logic [WORDS-1:0] match_q,
    input logic [WORDS-1:0] vld
);
    // R4: a read pulse only follows a read request that was not a search.
    p_rd_needs_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(read_next) && !$past(search_start)));

    // R4: a served read removes exactly one mark.
    p_one_per_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (read_next && !search_start && (match_q != '0)) |=>
        (rd_valid && ($countones($past(match_q)) == $countones(match_q) + 1)));

    // R9: a search cycle never produces a read pulse.
    p_search_no_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        search_start |=> !rd_valid);

    // R7: marks only disappear between searches.
    p_marks_shrink_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !search_start |=> ((match_q & ~$past(match_q)) == '0));

    // R3: no invalid entry is marked by a search.
    p_invalid_never_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        search_start |=> ((match_q & ~$past(vld)) == '0));

    // R6: done means no marks are left.
    p_done_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (match_q == '0));

    // R10: reset silences the outputs.
    p_reset_quiet_r10: assert property (@(posedge clk)
        !rst_n |=> (!rd_valid && !done));
endmodule

bind argmask_cam argmask_cam_checker #(.WORDS(WORDS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .search_start (search_start),
    .read_next    (read_next),
    .rd_valid     (rd_valid),
    .done         (done),
    .match_q      (match_q),
    .vld          (ent_valid)
);

// File: tb/argmask_cam_tb_top.sv
// Bench for argmask_cam: directed scenarios with literal expected values,
// plus a behavioural reference model compared against the outputs on
// every clock during a random phase.
module argmask_cam_tb_top;
    localparam int N = 8;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_idx = '0;
    logic [W-1:0] wr_data = '0;
    logic         wr_valid = 1'b0;
    logic [W-1:0] arg = '0;
    logic [W-1:0] mask = '0;
    logic         search_start = 1'b0;
    logic         read_next = 1'b0;
    logic [W-1:0] rd_data;
    logic         rd_valid;
    logic         done;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    argmask_cam dut_i (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_idx (wr_idx),
        .wr_data (wr_data), .wr_valid (wr_valid), .arg (arg), .mask (mask),
        .search_start (search_start), .read_next (read_next),
        .rd_data (rd_data), .rd_valid (rd_valid), .done (done)
    );

    // ---------------- reference model ----------------
    int unsigned m_mem [N];
    bit          m_vld [N];
    int unsigned m_snap [N];
    int          m_hits [$];
    bit          m_searched = 0;
    bit          exp_rv = 0;
    int unsigned exp_rd = 0;
    bit          model_live = 0;

    always @(posedge clk) begin
        exp_rv = 0;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin m_mem[i] = 0; m_vld[i] = 0; m_snap[i] = 0; end
            m_hits = {};
            m_searched = 0;
            exp_rd = 0;
        end else begin
            if (search_start) begin
                m_hits = {};
                for (int i = 0; i < N; i++) begin
                    m_snap[i] = m_mem[i];
                    if (m_vld[i] && (((m_mem[i] ^ arg) & mask) == 0)) m_hits.push_back(i);
                end
                m_searched = 1;
            end else if (read_next && m_hits.size() > 0) begin
                exp_rd = m_snap[m_hits.pop_front()];
                exp_rv = 1;
            end
            if (wr_en) begin
                m_mem[wr_idx] = wr_data;
                m_vld[wr_idx] = wr_valid;
            end
        end
        model_live = 1;
    end

    task automatic chk(input string tag, input int unsigned got, input int unsigned exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // Per-clock comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (model_live) begin
            chk("R4 rd_valid vs model", rd_valid, exp_rv);
            chk("R6 done vs model", done, (m_searched && m_hits.size() == 0));
            if (exp_rv) chk("R4 rd_data vs model", rd_data, exp_rd);
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic do_write(input int idx, input int unsigned d, input bit v);
        @(negedge clk);
        wr_en = 1; wr_idx = 3'(idx); wr_data = W'(d); wr_valid = v;
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic do_search(input int unsigned a, input int unsigned m);
        @(negedge clk);
        search_start = 1; arg = W'(a); mask = W'(m);
        @(posedge clk); #1;
        search_start = 0;
    endtask

    // One read request; returns the outputs seen in the following cycle.
    task automatic do_read(output bit v, output int unsigned d);
        @(negedge clk);
        read_next = 1;
        @(posedge clk); #1;
        read_next = 0;
        @(negedge clk);
        v = rd_valid; d = rd_data;
    endtask

    task automatic expect_read(input string tag, input int unsigned d_exp);
        bit v; int unsigned d;
        do_read(v, d);
        chk({tag, " valid"}, v, 1);
        chk({tag, " data"}, d, d_exp);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit v; int unsigned d;
        repeat (3) @(negedge clk);
        // R10: outputs quiet after reset.
        chk("R10 rd_valid after reset", rd_valid, 0);
        chk("R10 done after reset", done, 0);
        rst_n = 1;
        // R5: read before any search produces nothing.
        do_read(v, d);
        chk("R5 read before search", v, 0);
        // R10: table empty after reset; a match-all search finds nothing.
        do_search(16'h0000, 16'h0000);
        @(negedge clk);
        chk("R10 empty table search done", done, 1);

        // R1: load the table.
        do_write(0, 16'h0927, 0);
        do_write(1, 16'hB631, 1);
        do_write(2, 16'h5FC0, 1);
        do_write(3, 16'hD678, 1);
        do_write(4, 16'h0000, 1);
        do_write(5, 16'hF07F, 0);
        do_write(6, 16'h6F80, 1);
        do_write(7, 16'hF0F0, 1);

        // R2, R3: top-nibble search; entry 5 would match but is invalid.
        do_search(16'hF000, 16'hF000);
        @(negedge clk);
        chk("R2 done low with a match pending", done, 0);
        expect_read("R2 tag search", 16'hF0F0);
        chk("R3 done after single hit", done, 1);
        do_read(v, d);
        chk("R5 read past end", v, 0);

        // R8, R4, R7: empty mask, ascending order, mid-readout rewrite.
        do_search(16'h1234, 16'h0000);
        expect_read("R8 first", 16'hB631);
        expect_read("R4 second", 16'h5FC0);
        do_write(3, 16'h1234, 0);
        expect_read("R7 snapshot survives write", 16'hD678);
        expect_read("R4 fourth", 16'h0000);
        expect_read("R4 fifth", 16'h6F80);
        chk("R6 done low before last", done, 0);
        expect_read("R4 sixth", 16'hF0F0);
        chk("R6 done after last", done, 1);
        do_read(v, d);
        chk("R5 surplus read", v, 0);

        // R7: the rewrite is seen by the next search (entry 3 now invalid).
        do_search(16'h0000, 16'h0000);
        expect_read("R7 next search first", 16'hB631);
        expect_read("R7 next search second", 16'h5FC0);
        expect_read("R7 entry 3 skipped", 16'h0000);

        // R9: search and read together; search wins, new marks replace old.
        @(negedge clk);
        search_start = 1; read_next = 1; arg = 16'h0000; mask = 16'hFFFF;
        @(posedge clk); #1;
        search_start = 0; read_next = 0;
        @(negedge clk);
        chk("R9 no read on search cycle", rd_valid, 0);
        chk("R9 done low after search", done, 0);
        expect_read("R9 exact match", 16'h0000);
        chk("R9 old marks discarded", done, 1);

        // R1: new content found by a later search.
        do_write(0, 16'hABCD, 1);
        do_search(16'hABCD, 16'hFFFF);
        expect_read("R1 written word found", 16'hABCD);

        // R7: write in the same cycle as a search is not seen by it.
        @(negedge clk);
        wr_en = 1; wr_idx = 3'd5; wr_data = 16'h1111; wr_valid = 1;
        search_start = 1; arg = 16'h1111; mask = 16'hFFFF;
        @(posedge clk); #1;
        wr_en = 0; search_start = 0;
        @(negedge clk);
        chk("R7 same-cycle write unseen", done, 1);
        do_search(16'h1111, 16'hFFFF);
        expect_read("R7 same-cycle write seen later", 16'h1111);

        // Random phase, checked against the model every clock.
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            rst_n        = (k != 300);
            wr_en        = ($urandom % 3) == 0;
            wr_idx       = 3'($urandom % N);
            wr_data      = W'(($urandom % 4) << 12 | ($urandom % 4));
            wr_valid     = ($urandom % 4) != 0;
            arg          = W'(($urandom % 4) << 12 | ($urandom % 4));
            mask         = W'($urandom & 32'h0000_F00F);
            search_start = ($urandom % 8) == 0;
            read_next    = ($urandom % 2) == 0;
        end
        @(negedge clk);
        wr_en = 0; search_start = 0; read_next = 0; rst_n = 1;
        repeat (3) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule